// File: doc/BRIEF.md
# Word-shift compression step engine

The engine reduces a block of sixteen 64-bit words to eight 64-bit words. It loads the block into a sixteen-word shift state and applies a fixed number of rounds. In each round, a bitwise seven-operand nonlinear function of the lowest seven state words is XORed with a linear image of the top state word. That sum enters at the top while every other word moves down one place. The linear image is computed serially by a Galois shift register, one shift per cycle. The output folds the final state: each result word is a low-half state word XORed with its partner in the high half.

The datapath serves two word sizes, selected per request by a mode flag. Wide mode uses full 64-bit words. Narrow mode uses 32-bit words carried in the low half of each 64-bit lane. In narrow mode the upper halves are dropped on load and are zero in the result. Each mode has its own linear-map instance with its own tap polynomial. Requests and results move over valid/ready handshakes, and the engine holds one request at a time.

Top module: `wsc_engine`

## Requirements
- R1: After reset is released, `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both 1. From the next cycle, `req_ready_o` stays 0 until the result has been taken.
- R3: Load and round step.
  - Input word k (k = 0..15) occupies `req_blk_i[64k+63:64k]` and loads state word s[k].
  - In each round, new = F(s0,s1,s2,s3,s4,s5,s6) ^ L(s15), where F(a..g) = abcd ^ bce ^ af ^ dg ^ c ^ efg, applied bitwise (AND for products, XOR for sums).
  - After the round, s[i] takes the old s[i+1] for i < 15, and s15 takes new.
- R4: L(x) is a Galois shift register started at x and shifted W times, W being the word width of the mode (64 or 32). Each shift computes acc = (acc >> 1) ^ (acc[0] ? TAP : 0). TAP is `TAP_WIDE` in wide mode and `TAP_NARROW` in narrow mode.
- R5: After `NUM_ROUNDS` rounds, result word j (j = 0..7) is s[j] ^ s[j+8] and sits at `rsp_data_o[64j+63:64j]`.
- R6: `rsp_valid_o` rises exactly NUM_ROUNDS*(W+2) clock edges after the accepting edge. Each round takes one load cycle, W shift cycles and one commit cycle.
- R7: `req_mode_i` = 1 selects narrow mode. In narrow mode the upper 32 bits of every input word have no effect, and the upper 32 bits of every result word are 0. `req_mode_i` = 0 selects wide mode.
- R8: While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, `rsp_valid_o` stays 1 and `rsp_data_o` does not change.
- R9: A `req_valid_i` asserted while the engine is busy is ignored. The result is that of the request already accepted.
- R10: In the cycle after the edge where `rsp_valid_o` and `rsp_ready_i` are both 1, `rsp_valid_o` is 0 and `req_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Engine idle and able to accept |
| req_mode_i | input | 1 | 1 = narrow (32-bit) words, 0 = wide (64-bit) words |
| req_blk_i | input | 1024 | Sixteen input words, word k at bits 64k+63:64k |
| rsp_valid_o | output | 1 | Result present |
| rsp_ready_i | input | 1 | Consumer takes the result |
| rsp_data_o | output | 512 | Eight result words, word j at bits 64j+63:64j |

## Verification
The bench compares full results, in both modes and across several block patterns, with a reference model written from R3 to R5. A wrong tap, a wrong feedback term or an off-by-one in the shift count all change every result word. It measures the latency in clock edges, so a linear unit that performs one shift too many or too few is caught. In narrow mode it sends two blocks that differ only in their upper halves and expects identical results. A design that leaks those bits, or forgets to clear them, fails this check. It also sends a second request while the engine is busy and holds `rsp_ready_i` low for several cycles. A design that accepts the second request, or lets the result drift while it waits, is caught.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOAD,
    PH_WAIT,
    PH_DONE
  } phase_e;

  localparam int unsigned FB_ARITY = 7;
endpackage

// File: rtl/wsc_feedback.sv
module wsc_feedback #(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] c_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] e_i,
  input  logic [WIDTH-1:0] f_i,
  input  logic [WIDTH-1:0] g_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    y_o = (a_i & b_i & c_i & d_i)
        ^ (b_i & c_i & e_i)
        ^ (a_i & f_i)
        ^ (d_i & g_i)
        ^ c_i
        ^ (e_i & f_i & g_i);
  end
endmodule

// File: rtl/wsc_linear.sv
module wsc_linear #(
  parameter int unsigned    WIDTH = 64,
  parameter logic [WIDTH-1:0] TAP = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] word_i,
  output logic             done_o,
  output logic [WIDTH-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      acc_q <= word_i;
      cnt_q <= CNT_W'(WIDTH);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q != '0) begin
        acc_q <= (acc_q >> 1) ^ (acc_q[0] ? TAP : '0);
        cnt_q <= cnt_q - 1'b1;
      end else begin
        run_q <= 1'b0;
      end
    end
  end

  assign done_o = run_q && (cnt_q == '0);
  assign word_o = acc_q;
endmodule

// File: rtl/wsc_ctrl.sv
module wsc_ctrl
  import wsc_pkg::*;
#(
  parameter int unsigned NUM_ROUNDS = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_valid_i,
  input  logic   rsp_ready_i,
  input  logic   lin_done_i,
  output logic   req_ready_o,
  output logic   load_o,
  output logic   lin_start_o,
  output logic   commit_o,
  output logic   rsp_valid_o,
  output phase_e phase_o
);
  localparam int unsigned RND_W = (NUM_ROUNDS > 1) ? $clog2(NUM_ROUNDS) : 1;
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS - 1);

  phase_e           phase_q, phase_d;
  logic [RND_W-1:0] rnd_q, rnd_d;

  always_comb begin
    phase_d     = phase_q;
    rnd_d       = rnd_q;
    req_ready_o = 1'b0;
    load_o      = 1'b0;
    lin_start_o = 1'b0;
    commit_o    = 1'b0;
    rsp_valid_o = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        req_ready_o = 1'b1;
        if (req_valid_i) begin
          load_o  = 1'b1;
          rnd_d   = '0;
          phase_d = PH_LOAD;
        end
      end
      PH_LOAD: begin
        lin_start_o = 1'b1;
        phase_d     = PH_WAIT;
      end
      PH_WAIT: begin
        if (lin_done_i) begin
          commit_o = 1'b1;
          if (rnd_q == LAST_RND) begin
            phase_d = PH_DONE;
          end else begin
            rnd_d   = rnd_q + 1'b1;
            phase_d = PH_LOAD;
          end
        end
      end
      PH_DONE: begin
        rsp_valid_o = 1'b1;
        if (rsp_ready_i) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      rnd_q   <= '0;
    end else begin
      phase_q <= phase_d;
      rnd_q   <= rnd_d;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/wsc_engine.sv
module wsc_engine
  import wsc_pkg::*;
#(
  parameter int unsigned  WORD_W     = 64,
  parameter int unsigned  IN_WORDS   = 16,
  parameter int unsigned  NUM_ROUNDS = 8,
  parameter logic [63:0]  TAP_WIDE   = 64'hD800_0000_0000_0001,
  parameter logic [31:0]  TAP_NARROW = 32'hA300_0005
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic                          req_mode_i,
  input  logic [IN_WORDS*WORD_W-1:0]    req_blk_i,
  output logic                          rsp_valid_o,
  input  logic                          rsp_ready_i,
  output logic [IN_WORDS/2*WORD_W-1:0]  rsp_data_o
);
  localparam int unsigned HALF_W    = WORD_W / 2;
  localparam int unsigned OUT_WORDS = IN_WORDS / 2;
  localparam int unsigned TOP_IDX   = IN_WORDS - 1;

  logic [WORD_W-1:0] st_q [IN_WORDS];
  logic              mode_q;

  logic   load, lin_start, commit, lin_done;
  phase_e phase;

  logic [WORD_W-1:0] fb_word, lin_word, new_word;
  logic [HALF_W-1:0] lin_n_out;
  logic [WORD_W-1:0] lin_w_out;
  logic              lin_n_done, lin_w_done;

  wsc_ctrl #(.NUM_ROUNDS(NUM_ROUNDS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .rsp_ready_i(rsp_ready_i),
    .lin_done_i (lin_done),
    .req_ready_o(req_ready_o),
    .load_o     (load),
    .lin_start_o(lin_start),
    .commit_o   (commit),
    .rsp_valid_o(rsp_valid_o),
    .phase_o    (phase)
  );

  wsc_feedback #(.WIDTH(WORD_W)) u_fb (
    .a_i(st_q[0]), .b_i(st_q[1]), .c_i(st_q[2]), .d_i(st_q[3]),
    .e_i(st_q[4]), .f_i(st_q[5]), .g_i(st_q[6]),
    .y_o(fb_word)
  );

  wsc_linear #(.WIDTH(HALF_W), .TAP(TAP_NARROW)) u_lin_narrow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(lin_start && mode_q),
    .word_i (st_q[TOP_IDX][HALF_W-1:0]),
    .done_o (lin_n_done),
    .word_o (lin_n_out)
  );

  wsc_linear #(.WIDTH(WORD_W), .TAP(TAP_WIDE)) u_lin_wide (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(lin_start && !mode_q),
    .word_i (st_q[TOP_IDX]),
    .done_o (lin_w_done),
    .word_o (lin_w_out)
  );

  always_comb begin
    lin_done = mode_q ? lin_n_done : lin_w_done;
    lin_word = mode_q ? {{HALF_W{1'b0}}, lin_n_out} : lin_w_out;
    new_word = fb_word ^ lin_word;
    if (mode_q) new_word[WORD_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      for (int k = 0; k < IN_WORDS; k++) st_q[k] <= '0;
    end else if (load) begin
      mode_q <= req_mode_i;
      for (int k = 0; k < IN_WORDS; k++) begin
        st_q[k] <= req_blk_i[k*WORD_W +: WORD_W];
        if (req_mode_i) st_q[k][WORD_W-1:HALF_W] <= '0;
      end
    end else if (commit) begin
      for (int k = 0; k < TOP_IDX; k++) st_q[k] <= st_q[k+1];
      st_q[TOP_IDX] <= new_word;
    end
  end

  for (genvar j = 0; j < OUT_WORDS; j++) begin : g_fold
    assign rsp_data_o[j*WORD_W +: WORD_W] = st_q[j] ^ st_q[j+OUT_WORDS];
  end
endmodule

// File: rtl/wsc_engine_checker.sv
module wsc_engine_checker #(
  parameter int unsigned WORD_W   = 64,
  parameter int unsigned OUT_BITS = 512
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                req_ready_o,
  input logic                rsp_valid_o,
  input logic                rsp_ready_i,
  input logic [OUT_BITS-1:0] rsp_data_o,
  input logic                mode_q
);
  function automatic logic [OUT_BITS-1:0] upper_mask();
    logic [OUT_BITS-1:0] m = '0;
    for (int i = 0; i < OUT_BITS; i++) m[i] = ((i % WORD_W) >= WORD_W / 2);
    return m;
  endfunction

  localparam logic [OUT_BITS-1:0] HI_MASK = upper_mask();

  p_reset_idle_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> req_ready_o && !rsp_valid_o);

  p_busy_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  p_not_ready_with_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  p_narrow_upper_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && mode_q |-> (rsp_data_o & HI_MASK) == '0);

  p_hold_rsp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o));

  p_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ready_i |=> !rsp_valid_o && req_ready_o);
endmodule

bind wsc_engine wsc_engine_checker #(
  .WORD_W  (WORD_W),
  .OUT_BITS(IN_WORDS / 2 * WORD_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o),
  .rsp_ready_i(rsp_ready_i),
  .rsp_data_o (rsp_data_o),
  .mode_q     (mode_q)
);

// File: tb/wsc_engine_bench.sv
module wsc_engine_bench;
  localparam int unsigned ROUNDS  = 8;
  localparam logic [63:0] T_WIDE  = 64'hD800_0000_0000_0001;
  localparam logic [31:0] T_NARR  = 32'hA300_0005;
  localparam int          N_VEC   = 6;
  // {mode, seed}
  localparam logic [32:0] VEC [N_VEC] = '{
    {1'b0, 32'h0000_0000}, {1'b1, 32'h1234_5678}, {1'b0, 32'hFFFF_FFFF},
    {1'b1, 32'hDEAD_BEEF}, {1'b0, 32'h0F0F_3C3C}, {1'b1, 32'h0000_0001}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_mode = 1'b0;
  logic [1023:0] req_blk = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [511:0]  rsp_data;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wsc_engine u_wsc_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_mode_i(req_mode), .req_blk_i(req_blk),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_data_o(rsp_data)
  );

  function automatic logic [1023:0] gen_blk(logic [31:0] seed);
    logic [1023:0] b;
    for (int k = 0; k < 16; k++)
      b[k*64 +: 64] = {seed ^ (32'h9E37_79B9 * (k + 1)), (seed + 32'h7F4A_7C15 * k) ^ {k[7:0], 24'h5A}};
    return b;
  endfunction

  function automatic logic [63:0] lin_ref(logic [63:0] x, bit narrow);
    logic [63:0] acc = x;
    logic [63:0] tap = narrow ? {32'b0, T_NARR} : T_WIDE;
    int w = narrow ? 32 : 64;
    for (int i = 0; i < w; i++) acc = (acc >> 1) ^ (acc[0] ? tap : 64'b0);
    return acc;
  endfunction

  function automatic logic [511:0] model(bit narrow, logic [1023:0] blk);
    logic [63:0] s [16];
    logic [63:0] nw;
    logic [511:0] r;
    for (int k = 0; k < 16; k++) begin
      s[k] = blk[k*64 +: 64];
      if (narrow) s[k][63:32] = 32'b0;
    end
    for (int rd = 0; rd < ROUNDS; rd++) begin
      nw = (s[0] & s[1] & s[2] & s[3]) ^ (s[1] & s[2] & s[4]) ^ (s[0] & s[5])
         ^ (s[3] & s[6]) ^ s[2] ^ (s[4] & s[5] & s[6]);
      nw = nw ^ lin_ref(s[15], narrow);
      for (int k = 0; k < 15; k++) s[k] = s[k+1];
      s[15] = nw;
    end
    for (int j = 0; j < 8; j++) r[j*64 +: 64] = s[j] ^ s[j+8];
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // issue one request; optionally spam req_valid while busy and hold rsp_ready low
  task automatic run_req(bit narrow, logic [1023:0] blk, int hold, bit spam,
                         logic [1023:0] spam_blk, output logic [511:0] res);
    int n = 0;
    int exp_lat = ROUNDS * ((narrow ? 32 : 64) + 2);
    logic [511:0] first;
    @(negedge clk);
    check(req_ready == 1'b1, "R2", "ready before request", 512'(req_ready), 512'd1);
    req_valid = 1'b1; req_mode = narrow; req_blk = blk;
    @(posedge clk); #1;
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R2", "ready after accept", 512'(req_ready), 512'd0);
    if (spam) begin
      req_valid = 1'b1; req_mode = ~narrow; req_blk = spam_blk;
    end
    while (!rsp_valid && n < 5000) begin
      @(posedge clk); #1; n++;
    end
    req_valid = 1'b0;
    check(n == exp_lat, "R6", "latency", 512'(n), 512'(exp_lat));
    first = rsp_data;
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); #1;
      check(rsp_valid && rsp_data == first, "R8", "held result", rsp_data, first);
    end
    res = rsp_data;
    @(negedge clk); rsp_ready = 1'b1;
    @(posedge clk); #1; rsp_ready = 1'b0;
    check(!rsp_valid && req_ready, "R10", "release after take",
          512'({rsp_valid, req_ready}), 512'b01);
  endtask

  initial begin
    logic [511:0] res, res2, exp;
    logic [1023:0] b, b2;
    #3;
    check(req_ready == 1'b0 || rsp_valid == 1'b0, "R1", "in reset", 512'(rsp_valid), 512'd0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "after reset",
          512'({req_ready, rsp_valid}), 512'b10);

    for (int v = 0; v < N_VEC; v++) begin
      b = gen_blk(VEC[v][31:0]);
      run_req(VEC[v][32], b, 0, 1'b0, '0, res);
      exp = model(VEC[v][32], b);
      check(res == exp, "R3 R4 R5", "result", res, exp);
      if (VEC[v][32]) begin
        exp = '0;
        for (int j = 0; j < 8; j++) exp[j*64+32 +: 32] = 32'hFFFF_FFFF;
        check((res & exp) == '0, "R7", "narrow upper zero", res & exp, '0);
      end
    end

    // R7: upper halves ignored in narrow mode
    b = gen_blk(32'hCAFE_0001);
    b2 = b;
    for (int k = 0; k < 16; k++) b2[k*64+32 +: 32] = ~b[k*64+32 +: 32];
    run_req(1'b1, b, 0, 1'b0, '0, res);
    run_req(1'b1, b2, 0, 1'b0, '0, res2);
    check(res == res2, "R7", "upper halves ignored", res2, res);

    // R9 and R8: request while busy ignored, result held under back-pressure
    b = gen_blk(32'h600D_F00D);
    b2 = gen_blk(32'hBAD0_0BAD);
    run_req(1'b0, b, 5, 1'b1, b2, res);
    exp = model(1'b0, b);
    check(res == exp, "R9", "busy request ignored", res, exp);
    run_req(1'b1, b2, 3, 1'b1, b, res);
    exp = model(1'b1, b2);
    check(res == exp, "R9", "busy request ignored narrow", res, exp);

    // R1: reset mid-run returns to idle
    @(negedge clk); req_valid = 1'b1; req_mode = 1'b0; req_blk = b;
    @(posedge clk); #1; req_valid = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "reset mid-run",
          512'({req_ready, rsp_valid}), 512'b10);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule